// File: doc/BRIEF.md
# PRBS Lane Pattern Checker

This block checks one lane of a serial link under test. Each valid cycle it takes a 16-bit parallel receive word and compares it with a PRBS-7 stream (x^7 + x^6 + 1) that it generates locally. The checker has no fixed starting point, so it first synchronizes to the incoming stream. While it trains, every received word is loaded back into the local generator as the next seed. Lock is declared only after a programmable run of consecutive words that match the prediction.

Once locked, the generator runs freely. The number of differing bits in each word is added to a 16-bit error count. The count saturates at a selectable limit. When the count reaches that limit, the checker stops on its own and raises a margin flag. A margin sweep can use this flag to tell when the eye has closed.

Software controls the block through an enable, a count clear, a compare-engine restart, the run length needed for lock and the limit select. The status flags and the count are visible at all times.

Top module: `prbs_lane_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle. After that edge all four flags are low and `err_cnt` is 0.
- R2: If `en` is high in idle, `train_active` is high after the next edge. If `en` is low at an edge, all flags go low after that edge, and `err_cnt` keeps its value unless a clear is also applied.
- R3: While training, the first valid word only seeds the generator; receive bits [15:9] become the state, with bit 9 the oldest. Each later valid word is compared with the prediction and then reseeds the generator. A match extends the run of good words and a mismatch sets the run to zero. `train_done` rises after the edge on which the run reaches `train_len`. A `train_len` of 0 acts as 1.
- R4: The expected stream follows b[n] = b[n-7] XOR b[n-6]. Within a word the earliest bit sits in bit 0. After lock, a clean stream leaves the count at zero.
- R5: After lock, each valid word adds the number of differing bits to `err_cnt`. Mismatches seen during training are never counted. `err_cnt` never decreases except on a clear.
- R6: `max_sel` picks the limit: 0 gives 65535 (full scale), 1 gives 1024, 2 gives 256 and 3 gives 16. A sum that passes the limit is held at the limit and never wraps.
- R7: When the count reaches the limit, the block halts. `margin_err` goes high, `chk_active` goes low and `train_done` stays high. The count then stays frozen until a clear or restart.
- R8: A high `clr_cnt` at an edge sets `err_cnt` to 0, and any word in that cycle is not counted. In the halted state, the clear also starts training again.
- R9: A high `ce_rst` with `en` high sets the count to zero and restarts training from an unseeded state. If `en` is low, it only clears the count.
- R10: `chk_active` is high while training or locked. `train_active` is high only while training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Checker enable |
| clr_cnt | input | 1 | Clear the error count |
| ce_rst | input | 1 | Compare-engine restart: clear the count and retrain |
| train_len | input | 4 | Consecutive matching words needed for lock |
| max_sel | input | 2 | Error limit select |
| rx_data | input | 16 | Received parallel word |
| rx_valid | input | 1 | Received word is valid this cycle |
| train_active | output | 1 | Synchronization in progress |
| train_done | output | 1 | Locked to the received stream |
| chk_active | output | 1 | Checker is running |
| margin_err | output | 1 | Error limit reached, checker halted |
| err_cnt | output | 16 | Saturating bit-error count |

## Verification
The assertions assume that every control input has a known 0/1 value at each edge. The monotonic-count check also assumes that `max_sel` is not lowered beneath a count that is already higher. The design holds such a count rather than pulling it down. The bench changes `train_len` and `max_sel` only while `en` is low or right after a restart. Its random receive stream is always a real PRBS-7 sequence with sparse bit flips, so a corrupted seed is followed by a true resynchronization rather than by arbitrary data.

// File: rtl/prbs_chk_pkg.sv
// Shared types for the lane pattern checker.
package prbs_chk_pkg;

    // Checker control states; HALT is entered when the error limit is hit.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_LOCK  = 2'd2,
        ST_HALT  = 2'd3
    } chk_state_e;

endpackage

// File: rtl/prbs_chk_gen.sv
// Expected-word generator.
// Holds a Fibonacci LFSR and expands it by DATA_W steps per word. The word
// is combinational from the current state. The earliest generated bit is
// placed in bit 0. The state can be reseeded from the newest PRBS_LEN
// received bits (seed_bits[PRBS_LEN-1] is the newest bit and seed_bits[0]
// the oldest of them).
// Assumes DATA_W >= PRBS_LEN and that TAP_A/TAP_B are valid tap positions.
module prbs_chk_gen #(
    parameter int DATA_W   = 16,
    parameter int PRBS_LEN = 7,
    parameter int TAP_A    = 7,
    parameter int TAP_B    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                adv,
    input  logic [PRBS_LEN-1:0] seed_bits,
    output logic [DATA_W-1:0]   exp_word
);

    logic [PRBS_LEN-1:0] state_q;
    logic [PRBS_LEN-1:0] adv_state;
    logic [PRBS_LEN-1:0] seed_state;

    // Expand the state into one word of expected bits and the advanced state.
    always_comb begin
        logic [PRBS_LEN-1:0] s;
        logic                nb;
        s = state_q;
        exp_word = '0;
        for (int k = 0; k < DATA_W; k++) begin
            nb          = s[TAP_A-1] ^ s[TAP_B-1];
            exp_word[k] = nb;
            s           = {s[PRBS_LEN-2:0], nb};
        end
        adv_state = s;
    end

    // Map received bits onto the state: oldest received bit goes to the MSB.
    always_comb begin
        for (int i = 0; i < PRBS_LEN; i++) begin
            seed_state[PRBS_LEN-1-i] = seed_bits[i];
        end
    end

    // State register: reseed during training, free-run once locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (load) begin
            state_q <= seed_state;
        end else if (adv) begin
            state_q <= adv_state;
        end
    end

endmodule

// File: rtl/prbs_chk_sync.sv
// Lock detector.
// Counts consecutive matching words while training. The first checked word
// after a clear only marks the generator as seeded. A mismatch sets the run
// back to zero. lock pulses on the word that completes a run of
// run_len (0 treated as 1).
// Assumes clear is held while the checker is not training.
module prbs_chk_sync #(
    parameter int TRAIN_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               check,
    input  logic               match,
    input  logic [TRAIN_W-1:0] run_len,
    output logic               lock
);

    localparam int RW = TRAIN_W + 1;

    logic          seeded_q;
    logic [RW-1:0] good_q;
    logic [RW-1:0] good_nxt;
    logic [RW-1:0] need;

    // Required run length, with zero promoted to one.
    always_comb begin
        need     = (run_len == '0) ? RW'(1) : {1'b0, run_len};
        good_nxt = good_q + RW'(1);
        lock     = check && seeded_q && match && (good_nxt >= need);
    end

    // Seed flag and consecutive-good counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seeded_q <= 1'b0;
            good_q   <= '0;
        end else if (check) begin
            seeded_q <= 1'b1;
            if (seeded_q && match) begin
                good_q <= good_nxt;
            end else if (seeded_q) begin
                good_q <= '0;
            end
        end
    end

    // A mismatch on a seeded word must leave the run at zero.
    p_run_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (check && seeded_q && !match && !clear) |=> (good_q == '0));

endmodule

// File: rtl/prbs_chk_errcnt.sv
// Saturating bit-error counter.
// Adds the population count of (expected XOR received) on each accepted
// word. The count is held at the selected limit. A count already above a
// newly lowered limit is held, never reduced. hit flags an accepted word
// whose result reaches the limit.
// Assumes acc is never high in the same cycle as clr.
module prbs_chk_errcnt #(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int LIM_LOG1 = 10,
    parameter int LIM_LOG2 = 8,
    parameter int LIM_LOG3 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc,
    input  logic [DATA_W-1:0] exp_word,
    input  logic [DATA_W-1:0] rx_word,
    input  logic [1:0]        max_sel,
    output logic [CNT_W-1:0]  cnt,
    output logic              hit
);

    localparam int PW = $clog2(DATA_W + 1);
    localparam int SW = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pop;
    logic [SW-1:0]    lim_w;
    logic [SW-1:0]    sum;
    logic [CNT_W-1:0] nxt;

    // Count differing bits in the current word.
    always_comb begin
        logic [DATA_W-1:0] diff;
        diff = exp_word ^ rx_word;
        pop  = '0;
        for (int k = 0; k < DATA_W; k++) begin
            pop = pop + PW'(diff[k]);
        end
    end

    // Decode the limit select (0 = full scale of the counter).
    always_comb begin
        unique case (max_sel)
            2'd0: lim_w = {1'b0, {CNT_W{1'b1}}};
            2'd1: lim_w = SW'(1) << LIM_LOG1;
            2'd2: lim_w = SW'(1) << LIM_LOG2;
            default: lim_w = SW'(1) << LIM_LOG3;
        endcase
    end

    // Saturating next count and limit detection.
    always_comb begin
        sum = {1'b0, cnt_q} + SW'(pop);
        if ({1'b0, cnt_q} >= lim_w) begin
            nxt = cnt_q;
        end else if (sum >= lim_w) begin
            nxt = lim_w[CNT_W-1:0];
        end else begin
            nxt = sum[CNT_W-1:0];
        end
        hit = acc && ({1'b0, nxt} >= lim_w);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (acc) begin
            cnt_q <= nxt;
        end
    end

    assign cnt = cnt_q;

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    p_no_decrease_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ({1'b0, cnt_q} < lim_w) && $stable(max_sel)) |=> ({1'b0, cnt_q} <= $past(lim_w)));

endmodule

// File: rtl/prbs_lane_checker.sv
// Per-lane PRBS pattern checker (top).
// Sequences idle -> training -> locked -> halted. It ties together the
// expected-word generator, the lock detector and the saturating error
// counter. Status flags are decoded from the registered state.
// Assumes rx_data carries a PRBS_LEN-degree stream, earliest bit in bit 0.
module prbs_lane_checker
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int TRAIN_W  = 4,
    parameter int PRBS_LEN = 7,
    parameter int TAP_A    = 7,
    parameter int TAP_B    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               clr_cnt,
    input  logic               ce_rst,
    input  logic [TRAIN_W-1:0] train_len,
    input  logic [1:0]         max_sel,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_valid,
    output logic               train_active,
    output logic               train_done,
    output logic               chk_active,
    output logic               margin_err,
    output logic [CNT_W-1:0]   err_cnt
);

    localparam int SEED_LSB = DATA_W - PRBS_LEN;

    chk_state_e         st_q, st_d;
    logic [DATA_W-1:0]  exp_word;
    logic               run_ok;
    logic               check;
    logic               adv;
    logic               acc;
    logic               lock;
    logic               hit;
    logic               sync_clr;

    // Qualify per-cycle actions from state and controls.
    always_comb begin
        run_ok   = en && !ce_rst;
        check    = run_ok && rx_valid && (st_q == ST_TRAIN);
        adv      = run_ok && rx_valid && (st_q == ST_LOCK);
        acc      = adv && !clr_cnt;
        sync_clr = (st_q != ST_TRAIN) || !run_ok;
    end

    prbs_chk_gen #(
        .DATA_W  (DATA_W),
        .PRBS_LEN(PRBS_LEN),
        .TAP_A   (TAP_A),
        .TAP_B   (TAP_B)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (check),
        .adv      (adv),
        .seed_bits(rx_data[DATA_W-1:SEED_LSB]),
        .exp_word (exp_word)
    );

    prbs_chk_sync #(
        .TRAIN_W(TRAIN_W)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sync_clr),
        .check  (check),
        .match  (rx_data == exp_word),
        .run_len(train_len),
        .lock   (lock)
    );

    prbs_chk_errcnt #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cnt || ce_rst),
        .acc     (acc),
        .exp_word(exp_word),
        .rx_word (rx_data),
        .max_sel (max_sel),
        .cnt     (err_cnt),
        .hit     (hit)
    );

    // Next-state selection; enable and restart override the sequence.
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = ST_IDLE;
        end else if (ce_rst) begin
            st_d = ST_TRAIN;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_TRAIN;
                ST_TRAIN: if (lock) st_d = ST_LOCK;
                ST_LOCK:  if (hit) st_d = ST_HALT;
                ST_HALT:  if (clr_cnt) st_d = ST_TRAIN;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Flag decode from the registered state.
    always_comb begin
        train_active = (st_q == ST_TRAIN);
        train_done   = (st_q == ST_LOCK) || (st_q == ST_HALT);
        chk_active   = (st_q == ST_TRAIN) || (st_q == ST_LOCK);
        margin_err   = (st_q == ST_HALT);
    end

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!chk_active && !train_active && !train_done && !margin_err));

    p_lock_from_train_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_done) |-> $past(train_active));

    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_err && en && !ce_rst && !clr_cnt) |=> (margin_err && $stable(err_cnt)));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ce_rst) |=> (train_active && (err_cnt == '0)));

endmodule

// File: tb/sim_prbs_lane_checker.sv
module sim_prbs_lane_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_en = 1'b0, b_clr = 1'b0, b_cer = 1'b0, b_valid = 1'b0;
    logic [3:0]  b_len = 4'd9;
    logic [1:0]  b_sel = 2'd0;
    logic [15:0] b_data = '0;
    logic        train_active, train_done, chk_active, margin_err;
    logic [15:0] err_cnt;

    int n_chk = 0;
    int n_err = 0;

    // Reference state (0 idle, 1 training, 2 locked, 3 halted).
    int         m_st = 0;
    bit         m_seed = 0;
    int         m_good = 0;
    logic [6:0] m_h = 7'h7F;
    int         m_cnt = 0;
    logic [6:0] tx_h = 7'h5A;

    always #4 clk = ~clk;

    prbs_lane_checker u0 (
        .clk(clk), .rst_n(rst_n), .en(b_en), .clr_cnt(b_clr), .ce_rst(b_cer),
        .train_len(b_len), .max_sel(b_sel), .rx_data(b_data), .rx_valid(b_valid),
        .train_active(train_active), .train_done(train_done),
        .chk_active(chk_active), .margin_err(margin_err), .err_cnt(err_cnt)
    );

    // History h holds seven bits, oldest in bit 0; returns 23-bit extension.
    function automatic logic [22:0] bext(input logic [6:0] h);
        logic [22:0] v;
        v = '0;
        v[6:0] = h;
        for (int n = 7; n < 23; n++) v[n] = v[n-7] ^ v[n-6];
        return v;
    endfunction

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'd0: return 65535;
            2'd1: return 1024;
            2'd2: return 256;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance the reference model by one clock edge with the current inputs.
    task automatic model_edge();
        logic [22:0] v;
        logic [15:0] ex;
        int need, newc, lim;
        bit clrc;
        v = bext(m_h);
        ex = v[22:7];
        need = (b_len == 0) ? 1 : int'(b_len);
        lim = lim_of(b_sel);
        clrc = b_clr || b_cer;
        if (!b_en) begin
            m_st = 0; m_seed = 0; m_good = 0;
            if (clrc) m_cnt = 0;
        end else if (b_cer) begin
            m_st = 1; m_seed = 0; m_good = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: begin
                    m_st = 1; m_seed = 0; m_good = 0;
                    if (clrc) m_cnt = 0;
                end
                1: begin
                    if (clrc) m_cnt = 0;
                    if (b_valid) begin
                        if (m_seed && b_data == ex) begin
                            if (m_good + 1 >= need) m_st = 2;
                            m_good++;
                        end else if (m_seed) begin
                            m_good = 0;
                        end
                        m_seed = 1;
                        m_h = b_data[15:9];
                    end
                end
                2: begin
                    if (b_valid) begin
                        m_h = v[22:16];
                        if (clrc) m_cnt = 0;
                        else begin
                            if (m_cnt >= lim) newc = m_cnt;
                            else begin
                                newc = m_cnt + $countones(ex ^ b_data);
                                if (newc > lim) newc = lim;
                            end
                            m_cnt = newc;
                            if (newc >= lim) m_st = 3;
                        end
                    end else if (clrc) m_cnt = 0;
                end
                default: begin
                    if (clrc) begin
                        m_cnt = 0; m_st = 1; m_seed = 0; m_good = 0;
                    end
                end
            endcase
        end
    endtask

    // One clock: update the model, take the edge, compare all outputs.
    task automatic step();
        model_edge();
        @(posedge clk);
        #2;
        chk("R2 train_active", int'(train_active), int'(m_st == 1));
        chk("R3 train_done", int'(train_done), int'(m_st >= 2));
        chk("R10 chk_active", int'(chk_active), int'(m_st == 1 || m_st == 2));
        chk("R7 margin_err", int'(margin_err), int'(m_st == 3));
        chk("R5 err_cnt", int'(err_cnt), m_cnt);
        b_clr = 1'b0;
        b_cer = 1'b0;
    endtask

    // Send one transmitted word (optionally corrupted) or an idle cycle.
    task automatic send(input bit valid, input logic [15:0] mask);
        logic [22:0] v;
        b_valid = valid;
        if (valid) begin
            v = bext(tx_h);
            b_data = v[22:7] ^ mask;
            tx_h = v[22:16];
        end else begin
            b_data = 16'($urandom);
        end
        step();
    endtask

    // Restart training with run length 1, lock, and return.
    task automatic relock(input logic [1:0] sel);
        b_en = 1'b1; b_sel = sel; b_len = 4'd1; b_cer = 1'b1;
        send(1'b0, '0);
        send(1'b1, '0);
        send(1'b1, '0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        #(8 * 190000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'h0C0FFEE1);
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 train_active", int'(train_active), 0);
        chk("R1 train_done", int'(train_done), 0);
        chk("R1 chk_active", int'(chk_active), 0);
        chk("R1 margin_err", int'(margin_err), 0);
        chk("R1 err_cnt", int'(err_cnt), 0);
        rst_n = 1'b1;

        // R2: enable leaves idle
        b_en = 1'b1; b_len = 4'd9; b_sel = 2'd3;
        send(1'b0, '0);
        chk("R2 enter training", int'(train_active), 1);

        // R3: seed plus nine clean words
        send(1'b1, '0);
        repeat (8) send(1'b1, '0);
        chk("R3 not yet locked", int'(train_done), 0);
        send(1'b1, '0);
        chk("R3 locked after run", int'(train_done), 1);

        // R4: clean stream gives no errors
        repeat (40) send(1'b1, '0);
        chk("R4 clean stream", int'(err_cnt), 0);

        // R5: bit-error counting
        send(1'b1, 16'h0001);
        chk("R5 one flip", int'(err_cnt), 1);
        send(1'b0, '0);
        send(1'b1, 16'h00F0);
        chk("R5 four more", int'(err_cnt), 5);

        // R6/R7: limit 16 reached and held
        send(1'b1, 16'hFFFF);
        chk("R6 saturate 16", int'(err_cnt), 16);
        chk("R7 halted", int'(margin_err), 1);
        repeat (5) send(1'b1, 16'hFFFF);
        chk("R7 frozen", int'(err_cnt), 16);
        chk("R7 inactive", int'(chk_active), 0);

        // R8: clear from halt restarts training
        b_clr = 1'b1; b_len = 4'd3;
        send(1'b1, '0);
        chk("R8 cleared", int'(err_cnt), 0);
        chk("R8 retraining", int'(train_active), 1);

        // R3: mismatch resets the run (flip in a non-seed bit)
        send(1'b1, '0);
        send(1'b1, '0);
        send(1'b1, 16'h0001);
        send(1'b1, '0);
        send(1'b1, '0);
        chk("R3 run restarted", int'(train_done), 0);
        chk("R5 no count in training", int'(err_cnt), 0);
        send(1'b1, '0);
        chk("R3 locked after rerun", int'(train_done), 1);

        // R2: disable keeps the count
        send(1'b1, 16'h0003);
        b_en = 1'b0;
        send(1'b1, '0);
        chk("R2 count kept", int'(err_cnt), 2);
        chk("R2 flags low", int'(train_done), 0);

        // R9: restart clears and retrains
        b_en = 1'b1;
        send(1'b0, '0);
        b_cer = 1'b1;
        send(1'b1, '0);
        chk("R9 count cleared", int'(err_cnt), 0);
        chk("R9 training", int'(train_active), 1);

        // R3: zero run length acts as one
        b_len = 4'd0; b_cer = 1'b1;
        send(1'b0, '0);
        send(1'b1, '0);
        send(1'b1, '0);
        chk("R3 len zero", int'(train_done), 1);

        // R6: remaining limit encodings
        for (int s = 2; s >= 0; s--) begin
            relock(2'(s));
            while (!margin_err && n_chk < 150000) send(1'b1, 16'hFFFF);
            chk($sformatf("R6 limit sel %0d", s), int'(err_cnt), lim_of(2'(s)));
        end

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 249) == 0) b_en = ~b_en;
            if (!b_en) begin
                b_len = 4'($urandom_range(0, 15));
                b_sel = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 199) == 0) b_clr = 1'b1;
            if ($urandom_range(0, 299) == 0) b_cer = 1'b1;
            send($urandom_range(0, 3) != 0,
                 ($urandom_range(0, 19) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0);
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule